// File: doc/BRIEF.md
# Shared Issue Queue Entry Allocator

This block keeps the books for an issue queue that several hardware threads share. It holds one occupancy counter per thread and one global free-entry counter. From a static sharing policy, a percentage and the current set of active threads it works out how many entries each thread may hold at most. The dispatch stage raises a per-thread allocate strobe when it wants to place an instruction. The issue or completion logic raises a per-thread release strobe when an entry leaves. The block answers with a per-thread error pulse for every allocation it refuses. It also exposes global and per-thread free counts and full flags, so that dispatch can throttle each thread before it asks.

The per-thread caps are recomputed each cycle from the policy, the percentage and the active mask, and they are held in registers. A change to any of those inputs therefore takes effect one clock later. When a cap shrinks below a thread's current occupancy, that thread reads as full until its count drains below the new cap. The block stores no instruction payloads and does not choose which thread dispatches. It only grants or refuses the requests it receives.

Top module: `iq_entry_alloc`

## Requirements
- R1: With policy code 0 (dynamic sharing), and likewise with the unused code 3, every thread's cap equals ENTRIES.
- R2: With policy code 1 (partitioning), each thread whose `active_i` bit is 1 gets a cap of ENTRIES divided by the number of active threads, rounded down. Inactive threads get ENTRIES/THREADS, and so does every thread when no thread is active.
- R3: With policy code 2 (threshold), every cap is min(`pct_i`,100)*ENTRIES/100, rounded down. The exception is a mask with exactly one active thread: that thread's cap is ENTRIES.
- R4: A change to `policy_i`, `pct_i` or `active_i` shows in the caps, and so in `thread_free_o`, only after the next rising clock edge.
- R5: A thread's free count is its cap minus its occupancy, or 0 when the occupancy is at or above the cap. Its bit in `thread_full_o` is 1 exactly when that free count is 0.
- R6: `free_total_o` falls by one for each accepted allocation and rises by one for each effective release. `full_o` is 1 when it reaches 0. At all times `free_total_o` plus the sum of the thread occupancies equals ENTRIES.
- R7: An allocation is refused when its thread is full or when no global entry is left. A refused allocation sets that thread's `alloc_err_o` bit for the one cycle after the request and changes no counter.
- R8: When several threads request in one cycle and fewer global entries remain than eligible requests, the lowest-numbered threads are granted first. The rest are refused.
- R9: An accepted allocation and a release for the same thread in the same cycle leave that thread's occupancy and `free_total_o` unchanged.
- R10: A release for a thread whose occupancy is 0 is ignored unless it is paired with an accepted allocation.
- R11: While `rst` is high, all occupancies clear, `free_total_o` becomes ENTRIES, and `alloc_err_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy_i | input | 2 | Sharing policy: 0 dynamic, 1 partition, 2 threshold, 3 as dynamic |
| pct_i | input | 7 | Threshold percentage, values above 100 treated as 100 |
| active_i | input | THREADS | Active-thread mask |
| alloc_i | input | THREADS | Per-thread allocate strobes |
| release_i | input | THREADS | Per-thread release strobes |
| free_total_o | output | $clog2(ENTRIES+1) | Global free-entry count |
| thread_free_o | output | THREADS*$clog2(ENTRIES+1) | Per-thread free counts, thread t at bits t*W and up |
| full_o | output | 1 | No global entry free |
| thread_full_o | output | THREADS | Per-thread full flags |
| alloc_err_o | output | THREADS | Refused-allocation pulses, one cycle after the request |

## Verification
The bench targets cap arithmetic at awkward ratios, such as 16 split three ways and 30 percent of 16. A design that rounded up, or that skipped the one-active-thread override, would report free counts off by one or stuck at the threshold. It shrinks a thread's cap under its current occupancy. A design that subtracted without saturating would wrap the free count to a large value and keep granting. It also drives allocate and release together, on a busy thread and on an empty one, and issues more simultaneous requests than there are free entries. A design that got these wrong would drift the global count away from the sum of occupancies, or grant beyond the remaining space or out of priority order.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;

  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_PCT    = 2'd2,
    POL_RSVD   = 2'd3
  } share_pol_e;

endpackage

// File: rtl/iq_cap_table.sv
module iq_cap_table
  import iq_alloc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int THREADS = 4,
  parameter int CW      = $clog2(ENTRIES + 1),
  parameter int PW      = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  share_pol_e         pol_i,
  input  logic [PW-1:0]      pct_i,
  input  logic [THREADS-1:0] active_i,
  output logic [CW-1:0]      cap_o [THREADS]
);

  localparam int            AW       = $clog2(THREADS + 1);
  localparam int            PCT_MAX  = 100;
  localparam logic [CW-1:0] FULL_CAP = CW'(ENTRIES);
  localparam logic [CW-1:0] EVEN_CAP = CW'(ENTRIES / THREADS);

  logic [AW-1:0] act_n;
  logic [PW-1:0] pct_c;
  logic [CW-1:0] pct_cap;
  logic [CW-1:0] split_cap;
  logic [CW-1:0] cap_nx [THREADS];
  logic [CW-1:0] cap_q  [THREADS];

  function automatic logic [CW-1:0] share_of(input logic [AW-1:0] n);
    logic [CW-1:0] r;
    r = EVEN_CAP;
    for (int a = 1; a <= THREADS; a++) begin
      if (n == AW'(a)) r = CW'(ENTRIES / a);
    end
    return r;
  endfunction

  always_comb begin
    act_n = '0;
    for (int t = 0; t < THREADS; t++) act_n = act_n + AW'(active_i[t]);
    pct_c     = (pct_i > PW'(PCT_MAX)) ? PW'(PCT_MAX) : pct_i;
    pct_cap   = CW'((int'(pct_c) * ENTRIES) / PCT_MAX);
    split_cap = share_of(act_n);
    for (int t = 0; t < THREADS; t++) begin
      case (pol_i)
        POL_SPLIT: cap_nx[t] = active_i[t] ? split_cap : EVEN_CAP;
        POL_PCT:   cap_nx[t] = (active_i[t] && act_n == AW'(1)) ? FULL_CAP : pct_cap;
        default:   cap_nx[t] = FULL_CAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < THREADS; t++) cap_q[t] <= cap_nx[t];
  end

  assign cap_o = cap_q;

  for (genvar g = 0; g < THREADS; g++) begin : g_chk
    AST_SHARED_CAP: assert property (@(posedge clk) disable iff (rst)
      ($past(pol_i) == POL_SHARED) |-> (cap_q[g] == FULL_CAP)); // R1
    AST_SOLO_PCT: assert property (@(posedge clk) disable iff (rst)
      ($past(pol_i) == POL_PCT && $past(active_i) == (THREADS'(1) << g))
        |-> (cap_q[g] == FULL_CAP)); // R3
  end

endmodule

// File: rtl/iq_grant_arb.sv
module iq_grant_arb #(
  parameter int THREADS = 4,
  parameter int CW      = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [THREADS-1:0] req_i,
  input  logic [THREADS-1:0] ok_i,
  input  logic [CW-1:0]      room_i,
  output logic [THREADS-1:0] grant_o
);

  logic [CW-1:0] taken;

  always_comb begin
    taken = '0;
    for (int t = 0; t < THREADS; t++) begin
      grant_o[t] = 1'b0;
      if (req_i[t] && ok_i[t] && taken < room_i) begin
        grant_o[t] = 1'b1;
        taken      = taken + CW'(1);
      end
    end
  end

  AST_GRANT_ROOM: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_o) <= int'(room_i)); // R6

  for (genvar g = 1; g < THREADS; g++) begin : g_ord
    AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
      grant_o[g] |-> ((req_i[g-1:0] & ok_i[g-1:0] & ~grant_o[g-1:0]) == '0)); // R8
  end

endmodule

// File: rtl/iq_thread_ctr.sv
module iq_thread_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant_i,
  input  logic          release_i,
  input  logic [CW-1:0] cap_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] free_o,
  output logic          ok_o,
  output logic          full_o,
  output logic          rel_ok_o
);

  logic [CW-1:0] cnt_q;

  assign ok_o     = cnt_q < cap_i;
  assign full_o   = ~ok_o;
  assign free_o   = ok_o ? (cap_i - cnt_q) : '0;
  assign rel_ok_o = release_i && (cnt_q != '0 || grant_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (grant_i && !rel_ok_o) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (!grant_i && rel_ok_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grant_i && release_i) |=> $stable(cnt_q)); // R9
  AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && release_i && !grant_i) |=> (cnt_q == '0)); // R10
  AST_CAP_GUARD: assert property (@(posedge clk) disable iff (rst)
    grant_i |-> (cnt_q < cap_i)); // R7

endmodule

// File: rtl/iq_entry_alloc.sv
module iq_entry_alloc
  import iq_alloc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int THREADS = 4,
  parameter int CW      = $clog2(ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            policy_i,
  input  logic [6:0]            pct_i,
  input  logic [THREADS-1:0]    active_i,
  input  logic [THREADS-1:0]    alloc_i,
  input  logic [THREADS-1:0]    release_i,
  output logic [CW-1:0]         free_total_o,
  output logic [THREADS*CW-1:0] thread_free_o,
  output logic                  full_o,
  output logic [THREADS-1:0]    thread_full_o,
  output logic [THREADS-1:0]    alloc_err_o
);

  share_pol_e         pol_w;
  logic [CW-1:0]      cap_w  [THREADS];
  logic [CW-1:0]      cnt_w  [THREADS];
  logic [CW-1:0]      tfree_w[THREADS];
  logic [THREADS-1:0] ok_w, grant_w, rel_ok_w, tfull_w;
  logic [CW-1:0]      free_q, n_grant, n_rel;
  logic [THREADS-1:0] err_q;
  int                 occ_sum;

  assign pol_w = share_pol_e'(policy_i);

  iq_cap_table #(.ENTRIES(ENTRIES), .THREADS(THREADS), .CW(CW), .PW(7)) u_caps (
    .clk(clk), .rst(rst), .pol_i(pol_w), .pct_i(pct_i),
    .active_i(active_i), .cap_o(cap_w)
  );

  iq_grant_arb #(.THREADS(THREADS), .CW(CW)) u_arb (
    .clk(clk), .rst(rst), .req_i(alloc_i), .ok_i(ok_w),
    .room_i(free_q), .grant_o(grant_w)
  );

  for (genvar g = 0; g < THREADS; g++) begin : g_thr
    iq_thread_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst(rst), .grant_i(grant_w[g]), .release_i(release_i[g]),
      .cap_i(cap_w[g]), .cnt_o(cnt_w[g]), .free_o(tfree_w[g]),
      .ok_o(ok_w[g]), .full_o(tfull_w[g]), .rel_ok_o(rel_ok_w[g])
    );
    assign thread_free_o[g*CW +: CW] = tfree_w[g];
  end

  always_comb begin
    n_grant = '0;
    n_rel   = '0;
    occ_sum = 0;
    for (int t = 0; t < THREADS; t++) begin
      n_grant = n_grant + CW'(grant_w[t]);
      n_rel   = n_rel + CW'(rel_ok_w[t]);
      occ_sum = occ_sum + int'(cnt_w[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= CW'(ENTRIES);
      err_q  <= '0;
    end else begin
      free_q <= free_q - n_grant + n_rel;
      err_q  <= alloc_i & ~grant_w;
    end
  end

  assign free_total_o  = free_q;
  assign full_o        = (free_q == '0);
  assign thread_full_o = tfull_w;
  assign alloc_err_o   = err_q;

  AST_OCC_SUM: assert property (@(posedge clk) disable iff (rst)
    (int'(free_q) + occ_sum) == ENTRIES); // R6
  AST_REFUSE_STILL: assert property (@(posedge clk) disable iff (rst)
    (alloc_i != '0 && grant_w == '0 && rel_ok_w == '0) |=> $stable(free_q)); // R7

endmodule

// File: tb/iq_entry_alloc_bench.sv
module iq_entry_alloc_bench;
  localparam int N = 16, T = 4, CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]      policy;
  logic [6:0]      pct;
  logic [T-1:0]    active, alloc, rel;
  logic [CW-1:0]   free_total_o;
  logic [T*CW-1:0] thread_free_o;
  logic            full_o;
  logic [T-1:0]    thread_full_o, alloc_err_o;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  iq_entry_alloc #(.ENTRIES(N), .THREADS(T)) u_iq_entry_alloc (
    .clk(clk), .rst(rst), .policy_i(policy), .pct_i(pct), .active_i(active),
    .alloc_i(alloc), .release_i(rel), .free_total_o(free_total_o),
    .thread_free_o(thread_free_o), .full_o(full_o),
    .thread_full_o(thread_full_o), .alloc_err_o(alloc_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tf(input int t);
    return int'(thread_free_o[t*CW +: CW]);
  endfunction

  task automatic cyc(input logic [T-1:0] a, input logic [T-1:0] r);
    alloc = a; rel = r;
    @(posedge clk); @(negedge clk);
    alloc = '0; rel = '0;
  endtask

  task automatic rep(input logic [T-1:0] a, input logic [T-1:0] r, input int n);
    for (int i = 0; i < n; i++) cyc(a, r);
  endtask

  task automatic t_reset;
    policy = 2'd0; pct = 7'd50; active = 4'b1111; alloc = '0; rel = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 free after reset", int'(free_total_o), N);
    chk("R11 err after reset", int'(alloc_err_o), 0);
    chk("R11 full after reset", int'(full_o), 0);
    chk("R11 thread0 free after reset", tf(0), N);
    rst = 1'b0;
    cyc('0, '0);
    chk("R11 free first cycle", int'(free_total_o), N);
  endtask

  task automatic t_dynamic;
    rep(4'b0001, '0, 5);
    chk("R1 thread0 free", tf(0), 11);
    chk("R1 thread1 free", tf(1), 16);
    chk("R6 global free", int'(free_total_o), 11);
    rep('0, 4'b0001, 5);
    chk("R6 global free drained", int'(free_total_o), N);
  endtask

  task automatic t_global_full;
    rep(4'b1111, '0, 4);
    chk("R6 free at full", int'(free_total_o), 0);
    chk("R6 full flag", int'(full_o), 1);
    chk("R5 thread2 free", tf(2), 12);
    cyc(4'b0010, '0);
    chk("R7 err on global full", int'(alloc_err_o), 2);
    chk("R7 free unchanged", int'(free_total_o), 0);
    chk("R7 thread1 unchanged", tf(1), 12);
    cyc('0, '0);
    chk("R7 err one cycle", int'(alloc_err_o), 0);
    rep('0, 4'b1111, 4);
    chk("R6 drained", int'(free_total_o), N);
  endtask

  task automatic t_order;
    rep(4'b0001, '0, 14);
    chk("R6 free two left", int'(free_total_o), 2);
    cyc(4'b1110, '0);
    chk("R8 err on highest", int'(alloc_err_o), 8);
    chk("R8 free exhausted", int'(free_total_o), 0);
    chk("R8 thread1 granted", tf(1), 15);
    chk("R8 thread2 granted", tf(2), 15);
    chk("R8 thread3 refused", tf(3), 16);
    rep('0, 4'b0001, 14);
    cyc('0, 4'b0110);
    chk("R6 drained after order", int'(free_total_o), N);
  endtask

  task automatic t_pair;
    rep(4'b0100, '0, 2);
    chk("R6 thread2 two", tf(2), 14);
    cyc(4'b0100, 4'b0100);
    chk("R9 thread2 held", tf(2), 14);
    chk("R9 free held", int'(free_total_o), 14);
    chk("R9 no err", int'(alloc_err_o), 0);
    cyc(4'b1000, 4'b1000);
    chk("R9 pair on empty thread", tf(3), 16);
    chk("R9 pair on empty free", int'(free_total_o), 14);
    rep('0, 4'b0100, 2);
    chk("R6 drained after pair", int'(free_total_o), N);
  endtask

  task automatic t_idle_release;
    cyc('0, 4'b1000);
    chk("R10 free no rise", int'(free_total_o), N);
    chk("R10 thread3 free", tf(3), 16);
    cyc('0, 4'b1111);
    chk("R10 all idle release", int'(free_total_o), N);
    chk("R10 thread0 free", tf(0), 16);
  endtask

  task automatic t_split;
    policy = 2'd1; active = 4'b1111;
    cyc('0, '0);
    chk("R2 four active", tf(0), 4);
    active = 4'b0011; cyc('0, '0);
    chk("R2 two active", tf(0), 8);
    chk("R2 inactive even", tf(2), 4);
    active = 4'b0000; cyc('0, '0);
    chk("R2 none active", tf(1), 4);
    active = 4'b0111; cyc('0, '0);
    chk("R2 three active floor", tf(0), 5);
    chk("R2 inactive three", tf(3), 4);
    active = 4'b0001;
    #1;
    chk("R4 cap before edge", tf(0), 5);
    @(negedge clk);
    chk("R4 cap after edge", tf(0), 16);
  endtask

  task automatic t_shrink;
    rep(4'b0001, '0, 10);
    chk("R5 thread0 free", tf(0), 6);
    active = 4'b1111; cyc('0, '0);
    chk("R5 saturated free", tf(0), 0);
    chk("R5 full flag", int'(thread_full_o[0]), 1);
    cyc(4'b0001, '0);
    chk("R7 err on thread full", int'(alloc_err_o), 1);
    chk("R7 free unchanged", int'(free_total_o), 6);
    rep('0, 4'b0001, 10);
    chk("R5 back under cap", tf(0), 4);
    chk("R6 drained after shrink", int'(free_total_o), N);
  endtask

  task automatic t_threshold;
    policy = 2'd2; pct = 7'd50; active = 4'b1111; cyc('0, '0);
    chk("R3 half", tf(0), 8);
    pct = 7'd30; cyc('0, '0);
    chk("R3 thirty floor", tf(1), 4);
    pct = 7'd120; cyc('0, '0);
    chk("R3 clip", tf(2), 16);
    pct = 7'd30; active = 4'b0100; cyc('0, '0);
    chk("R3 solo full", tf(2), 16);
    chk("R3 others thresh", tf(0), 4);
    pct = 7'd0; active = 4'b1111; cyc('0, '0);
    chk("R5 zero cap full", int'(thread_full_o), 15);
    cyc(4'b0001, '0);
    chk("R7 err zero cap", int'(alloc_err_o), 1);
    chk("R7 free kept", int'(free_total_o), N);
    policy = 2'd3; cyc('0, '0);
    chk("R1 code three shared", tf(0), 16);
  endtask

  initial begin
    t_reset();
    t_dynamic();
    t_global_full();
    t_order();
    t_pair();
    t_idle_release();
    t_split();
    t_shrink();
    t_threshold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule